// File: doc/BRIEF.md
# Static Memory Bus Timing Controller

This block runs single accesses to asynchronous external static memory, such as flash or SRAM, over a 16-bit data bus. Each chip-select line has its own set of timing codes. These codes set how many controller clock cycles pass before output enable or write enable asserts, how long the whole access lasts, and how many idle cycles separate one access from the next. The internal side takes a request through a ready/valid handshake. A request carries an address, write data, a direction flag, byte enables and a chip-select index. When the access is finished, the block pulses a done flag and, for a read, returns the captured data.

An accepted request is latched along with the decoded timing of its chip. The addressed chip select then stays low for the access length. Read enable or write enable asserts at an offset inside that window. All strobes return high together at the end of the window. A turnaround gap follows, during which no new request is accepted. A global enable input blocks new accesses and holds every strobe high while it is low.

Top module: `smem_timing_ctrl`

## Requirements
- R1: While reset is held low, all chip selects, read enable, write enable and both byte-lane strobes are high, the data bus is not driven and `rsp_done` is low.
- R2: For a write with write-delay code n (0..15), write enable goes low in access cycle n+2 and stays low to the end of the access. Access cycle 1 is the first cycle in which chip select is low.
- R3: For a read with read-enable code n (0..15), read enable goes low in access cycle n+1 and stays low to the end of the access. Read enable and write enable are never low together.
- R4: A read keeps chip select low for n+1 cycles for read-time code n (0..31), so code 31 gives 32 cycles. Data on `mem_dq_in` is captured in the last of those cycles. `rsp_done` is high for exactly one cycle, the cycle after the access ends, and `rsp_rdata` carries the captured data in that cycle.
- R5: A write keeps chip select low for n+2 cycles for write-time code n (0..31), so code 31 gives 33 cycles. `mem_dq_oe` is high and `mem_dq_out` carries the write data exactly while write enable is low.
- R6: After each access, n+1 idle cycles follow for turnaround code n (0..15), so code 15 gives 16 cycles. During these cycles all strobes are high and `req_ready` is low. `req_ready` rises in the cycle after the last idle cycle.
- R7: Lane strobe bit 0 (lower byte) and bit 1 (upper byte) are low for the whole access when the matching `req_be` bit is 1. A lane whose enable bit is 0 stays high for the entire access.
- R8: Only the chip-select bit given by `req_sel` goes low. Its timing comes from that chip's own code fields, which sit at bit slice [i*w +: w] of each configuration vector for chip i.
- R9: While `enable` is low, `req_ready` is low, no request is accepted even if `req_valid` is held, and all strobes stay high.
- R10: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Chip select goes low in the following cycle. A request presented while the block is busy waits with `req_valid` held until `req_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global bus enable |
| cfg_we_dly | input | NCS*4 | Write-enable delay codes, one 4-bit field per chip |
| cfg_oe_dly | input | NCS*4 | Read-enable delay codes, one 4-bit field per chip |
| cfg_rd_time | input | NCS*5 | Read access time codes, one 5-bit field per chip |
| cfg_wr_time | input | NCS*5 | Write access time codes, one 5-bit field per chip |
| cfg_turn | input | NCS*4 | Turnaround codes, one 4-bit field per chip |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 for write, 0 for read |
| req_sel | input | SEL_W | Chip-select index |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte-lane enables |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid while rsp_done is high after a read |
| mem_addr | output | AW | Memory address bus |
| mem_dq_out | output | DW | Data driven toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DW | Data returned by memory |
| mem_cs_n | output | NCS | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low read enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lane_n | output | DW/8 | Active-low byte-lane strobes, bit 0 lower byte |

## Verification
The bench uses the default parameters: two chip selects, a 16-bit data bus and a 23-bit address. It drives every code field from ports, so one build can give the two chips contrasting settings. Chip 0 runs with all codes at zero, which gives the shortest accesses, a write enable that asserts only in the last access cycle, and a one-cycle turnaround. Chip 1 first runs mid-range codes and is then moved to the saturated top codes. This exercises the 32-cycle read, the 33-cycle write, late strobe offsets and the 16-cycle gap, all compared against a cycle-level model.

// File: rtl/smem_pkg.sv
// Shared definitions for the static memory timing controller.
// Holds the code field widths, the phase encoding, the decoded timing record
// and the functions that turn a register code into cycle counts.
package smem_pkg;

    localparam int WE_CODE_W   = 4;
    localparam int OE_CODE_W   = 4;
    localparam int RD_CODE_W   = 5;
    localparam int WR_CODE_W   = 5;
    localparam int TURN_CODE_W = 4;
    // Largest count is 33 (write code 31), six bits hold it.
    localparam int CNT_W       = 6;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACCESS = 2'd1,
        PH_TURN   = 2'd2
    } phase_t;

    // Decoded timing for one chip: start cycles are 1-based access cycles.
    typedef struct packed {
        logic [CNT_W-1:0] we_start;
        logic [CNT_W-1:0] oe_start;
        logic [CNT_W-1:0] rd_len;
        logic [CNT_W-1:0] wr_len;
        logic [CNT_W-1:0] turn_len;
    } timing_t;

    // Write enable waits n+1 cycles after chip select, so it starts in cycle n+2.
    function automatic logic [CNT_W-1:0] we_start_of(input logic [WE_CODE_W-1:0] code);
        return CNT_W'(code) + CNT_W'(2);
    endfunction

    // Read enable waits n cycles, so it starts in cycle n+1.
    function automatic logic [CNT_W-1:0] oe_start_of(input logic [OE_CODE_W-1:0] code);
        return CNT_W'(code) + CNT_W'(1);
    endfunction

    // Read length n+1; the top code 31 lands on 32.
    function automatic logic [CNT_W-1:0] rd_len_of(input logic [RD_CODE_W-1:0] code);
        return CNT_W'(code) + CNT_W'(1);
    endfunction

    // Write length n+2; the top code 31 lands on 33.
    function automatic logic [CNT_W-1:0] wr_len_of(input logic [WR_CODE_W-1:0] code);
        return CNT_W'(code) + CNT_W'(2);
    endfunction

    // Turnaround n+1; the top code 15 lands on 16.
    function automatic logic [CNT_W-1:0] turn_len_of(input logic [TURN_CODE_W-1:0] code);
        return CNT_W'(code) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/smem_timing_decode.sv
// Decodes the per-chip timing code fields into cycle counts and selects the
// set that belongs to the requested chip.
// Assumes the code vectors are packed with chip i at slice [i*w +: w].
module smem_timing_decode
    import smem_pkg::*;
#(
    parameter int NCS   = 2,
    parameter int SEL_W = 1
) (
    input  logic [NCS*WE_CODE_W-1:0]   cfg_we_dly,
    input  logic [NCS*OE_CODE_W-1:0]   cfg_oe_dly,
    input  logic [NCS*RD_CODE_W-1:0]   cfg_rd_time,
    input  logic [NCS*WR_CODE_W-1:0]   cfg_wr_time,
    input  logic [NCS*TURN_CODE_W-1:0] cfg_turn,
    input  logic [SEL_W-1:0]           sel,
    output timing_t                    timing
);

    timing_t per_chip [NCS];

    // One decoder per chip select.
    for (genvar c = 0; c < NCS; c++) begin : g_chip
        assign per_chip[c].we_start = we_start_of(cfg_we_dly[c*WE_CODE_W +: WE_CODE_W]);
        assign per_chip[c].oe_start = oe_start_of(cfg_oe_dly[c*OE_CODE_W +: OE_CODE_W]);
        assign per_chip[c].rd_len   = rd_len_of(cfg_rd_time[c*RD_CODE_W +: RD_CODE_W]);
        assign per_chip[c].wr_len   = wr_len_of(cfg_wr_time[c*WR_CODE_W +: WR_CODE_W]);
        assign per_chip[c].turn_len = turn_len_of(cfg_turn[c*TURN_CODE_W +: TURN_CODE_W]);
    end

    // Pick the decoded set for the selected chip; out-of-range indices read chip 0.
    always_comb begin
        timing = per_chip[0];
        for (int c = 1; c < NCS; c++) begin
            if (int'(sel) == c) timing = per_chip[c];
        end
    end

endmodule

// File: rtl/smem_phase_seq.sv
// Access sequencer: accepts one request at a time, latches it with its decoded
// timing, counts access cycles, captures read data in the last cycle, then
// counts the turnaround gap before becoming ready again.
// Assumes the timing record is stable in the cycle a request is accepted.
module smem_phase_seq
    import smem_pkg::*;
#(
    parameter int AW    = 23,
    parameter int DW    = 16,
    parameter int LANES = 2,
    parameter int SEL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  timing_t           timing,
    input  logic [DW-1:0]     mem_dq_in,
    output phase_t            phase,
    output logic [CNT_W-1:0]  cnt,
    output logic              cur_write,
    output logic [SEL_W-1:0]  cur_sel,
    output logic [AW-1:0]     cur_addr,
    output logic [DW-1:0]     cur_wdata,
    output logic [LANES-1:0]  cur_be,
    output logic [CNT_W-1:0]  cur_we_start,
    output logic [CNT_W-1:0]  cur_oe_start,
    output logic              rsp_done,
    output logic [DW-1:0]     rsp_rdata
);

    logic [CNT_W-1:0] acc_len;
    logic [CNT_W-1:0] turn_len;
    logic             accept;

    // Handshake: take a request only when idle and globally enabled.
    assign req_ready = enable && (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    // Phase, counter, latched request and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_IDLE;
            cnt          <= '0;
            cur_write    <= 1'b0;
            cur_sel      <= '0;
            cur_addr     <= '0;
            cur_wdata    <= '0;
            cur_be       <= '0;
            cur_we_start <= '0;
            cur_oe_start <= '0;
            acc_len      <= '0;
            turn_len     <= '0;
            rsp_done     <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            rsp_done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        cur_write    <= req_write;
                        cur_sel      <= req_sel;
                        cur_addr     <= req_addr;
                        cur_wdata    <= req_wdata;
                        cur_be       <= req_be;
                        cur_we_start <= timing.we_start;
                        cur_oe_start <= timing.oe_start;
                        acc_len      <= req_write ? timing.wr_len : timing.rd_len;
                        turn_len     <= timing.turn_len;
                        cnt          <= CNT_W'(1);
                        phase        <= PH_ACCESS;
                    end
                end
                PH_ACCESS: begin
                    if (cnt == acc_len) begin
                        if (!cur_write) rsp_rdata <= mem_dq_in;
                        rsp_done <= 1'b1;
                        cnt      <= CNT_W'(1);
                        phase    <= PH_TURN;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_TURN: begin
                    if (cnt == turn_len) begin
                        cnt   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    cnt   <= '0;
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/smem_strobe_gen.sv
// Pin generator: derives chip selects, read/write enables, lane strobes and
// data drive from the sequencer phase and access-cycle count.
// Assumes the count is 1-based inside the access phase; all outputs are gated
// by the global enable.
module smem_strobe_gen
    import smem_pkg::*;
#(
    parameter int NCS   = 2,
    parameter int DW    = 16,
    parameter int LANES = 2,
    parameter int SEL_W = 1
) (
    input  logic              enable,
    input  phase_t            phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cur_write,
    input  logic [SEL_W-1:0]  cur_sel,
    input  logic [DW-1:0]     cur_wdata,
    input  logic [LANES-1:0]  cur_be,
    input  logic [CNT_W-1:0]  cur_we_start,
    input  logic [CNT_W-1:0]  cur_oe_start,
    output logic [NCS-1:0]    mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_lane_n,
    output logic [DW-1:0]     mem_dq_out,
    output logic              mem_dq_oe
);

    logic active;
    logic we_on;

    // Bus is live only inside the access phase and while enabled.
    assign active = enable && (phase == PH_ACCESS);

    // One chip select per chip, low only for the latched index.
    for (genvar c = 0; c < NCS; c++) begin : g_cs
        assign mem_cs_n[c] = !(active && (int'(cur_sel) == c));
    end

    // One strobe per byte lane, following the latched byte enables.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign mem_lane_n[l] = !(active && cur_be[l]);
    end

    // Enables assert from their start cycle through the end of the access.
    assign we_on      = active && cur_write && (cnt >= cur_we_start);
    assign mem_we_n   = !we_on;
    assign mem_oe_n   = !(active && !cur_write && (cnt >= cur_oe_start));
    assign mem_dq_oe  = we_on;
    assign mem_dq_out = cur_wdata;

endmodule

// File: rtl/smem_timing_ctrl.sv
// Top of the static memory timing controller: per-chip code decode, access
// sequencer and pin generator.
// Assumes code vectors change only while the block is idle.
module smem_timing_ctrl
    import smem_pkg::*;
#(
    parameter int NCS = 2,
    parameter int AW  = 23,
    parameter int DW  = 16,
    localparam int LANES = DW / 8,
    localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable,
    input  logic [NCS*WE_CODE_W-1:0]     cfg_we_dly,
    input  logic [NCS*OE_CODE_W-1:0]     cfg_oe_dly,
    input  logic [NCS*RD_CODE_W-1:0]     cfg_rd_time,
    input  logic [NCS*WR_CODE_W-1:0]     cfg_wr_time,
    input  logic [NCS*TURN_CODE_W-1:0]   cfg_turn,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [SEL_W-1:0]             req_sel,
    input  logic [AW-1:0]                req_addr,
    input  logic [DW-1:0]                req_wdata,
    input  logic [LANES-1:0]             req_be,
    output logic                         rsp_done,
    output logic [DW-1:0]                rsp_rdata,
    output logic [AW-1:0]                mem_addr,
    output logic [DW-1:0]                mem_dq_out,
    output logic                         mem_dq_oe,
    input  logic [DW-1:0]                mem_dq_in,
    output logic [NCS-1:0]               mem_cs_n,
    output logic                         mem_oe_n,
    output logic                         mem_we_n,
    output logic [LANES-1:0]             mem_lane_n
);

    timing_t          timing;
    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic             cur_write;
    logic [SEL_W-1:0] cur_sel;
    logic [DW-1:0]    cur_wdata;
    logic [LANES-1:0] cur_be;
    logic [CNT_W-1:0] cur_we_start;
    logic [CNT_W-1:0] cur_oe_start;

    smem_timing_decode #(.NCS(NCS), .SEL_W(SEL_W)) u_decode (
        .cfg_we_dly  (cfg_we_dly),
        .cfg_oe_dly  (cfg_oe_dly),
        .cfg_rd_time (cfg_rd_time),
        .cfg_wr_time (cfg_wr_time),
        .cfg_turn    (cfg_turn),
        .sel         (req_sel),
        .timing      (timing)
    );

    smem_phase_seq #(.AW(AW), .DW(DW), .LANES(LANES), .SEL_W(SEL_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_sel      (req_sel),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_be       (req_be),
        .timing       (timing),
        .mem_dq_in    (mem_dq_in),
        .phase        (phase),
        .cnt          (cnt),
        .cur_write    (cur_write),
        .cur_sel      (cur_sel),
        .cur_addr     (mem_addr),
        .cur_wdata    (cur_wdata),
        .cur_be       (cur_be),
        .cur_we_start (cur_we_start),
        .cur_oe_start (cur_oe_start),
        .rsp_done     (rsp_done),
        .rsp_rdata    (rsp_rdata)
    );

    smem_strobe_gen #(.NCS(NCS), .DW(DW), .LANES(LANES), .SEL_W(SEL_W)) u_pins (
        .enable       (enable),
        .phase        (phase),
        .cnt          (cnt),
        .cur_write    (cur_write),
        .cur_sel      (cur_sel),
        .cur_wdata    (cur_wdata),
        .cur_be       (cur_be),
        .cur_we_start (cur_we_start),
        .cur_oe_start (cur_oe_start),
        .mem_cs_n     (mem_cs_n),
        .mem_oe_n     (mem_oe_n),
        .mem_we_n     (mem_we_n),
        .mem_lane_n   (mem_lane_n),
        .mem_dq_out   (mem_dq_out),
        .mem_dq_oe    (mem_dq_oe)
    );

endmodule

// File: rtl/smem_timing_ctrl_checker.sv
// Port-level protocol checks for the static memory timing controller,
// bound to every instance of the top module.
module smem_timing_ctrl_checker #(
    parameter int NCS   = 2,
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_done,
    input logic [NCS-1:0]   mem_cs_n,
    input logic             mem_oe_n,
    input logic             mem_we_n,
    input logic [LANES-1:0] mem_lane_n,
    input logic             mem_dq_oe
);

    // R8: at most one chip select is low.
    a_r8_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cs_n) <= 1);

    // R3: read and write enables never overlap.
    a_r3_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_oe_n || mem_we_n);

    // R7: a lane strobe is low only inside a chip-select window.
    a_r7_lane_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lane_n != {LANES{1'b1}}) |-> (mem_cs_n != {NCS{1'b1}}));

    // R5: data is driven only during a write with read enable high.
    a_r5_dq_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && (mem_cs_n != {NCS{1'b1}})));

    // R9: a disabled bus is quiet and refuses requests.
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> ((mem_cs_n == {NCS{1'b1}}) && mem_oe_n && mem_we_n && !req_ready));

    // R4: the done pulse directly follows a cycle with a chip select low.
    a_r4_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && $past(enable)) |-> ($past(mem_cs_n) != {NCS{1'b1}}));

    // R6: the turnaround gap has begun when done is high.
    a_r6_turn_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);

    // R10: an accepted request makes the block busy in the next cycle.
    a_r10_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind smem_timing_ctrl smem_timing_ctrl_checker #(.NCS(NCS), .LANES(LANES)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_lane_n (mem_lane_n),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_smem_timing_ctrl.sv
// Bench: behavioural cycle model of the access protocol compared on every clock.
module tb_smem_timing_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = CLK_PERIOD / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic [3:0]  b_wen [2];
    logic [3:0]  b_oen [2];
    logic [4:0]  b_rd  [2];
    logic [4:0]  b_wr  [2];
    logic [3:0]  b_trn [2];
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [0:0]  req_sel = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b00;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [22:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;
    logic [1:0]  mem_cs_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic [1:0]  mem_lane_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: read data is a fixed function of the address.
    assign mem_dq_in = mem_addr[15:0] ^ 16'h5A3C;

    smem_timing_ctrl dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_we_dly({b_wen[1], b_wen[0]}), .cfg_oe_dly({b_oen[1], b_oen[0]}),
        .cfg_rd_time({b_rd[1], b_rd[0]}), .cfg_wr_time({b_wr[1], b_wr[0]}),
        .cfg_turn({b_trn[1], b_trn[0]}),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_sel(req_sel), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lane_n(mem_lane_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state: 0 idle, 1 access, 2 turnaround.
    int          m_st = 0, m_k = 0, m_len = 0, m_t = 0, m_tlen = 0;
    int          m_oen = 0, m_wen = 0, m_sel = 0;
    bit          m_wr = 0;
    logic [1:0]  m_be = '0;
    logic [22:0] m_addr = '0;
    logic [15:0] m_wdata = '0, m_rdata = '0;
    int          cs1_run = 0, cs1_last = 0;

    // Model update at each edge from the requirement rules.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: if (enable && req_valid) begin
                    m_sel  = int'(req_sel);
                    m_wr   = req_write;
                    m_be   = req_be;
                    m_addr = req_addr;
                    m_wdata = req_wdata;
                    m_oen  = int'(b_oen[m_sel]);
                    m_wen  = int'(b_wen[m_sel]);
                    m_len  = m_wr ? int'(b_wr[m_sel]) + 2 : int'(b_rd[m_sel]) + 1;
                    m_tlen = int'(b_trn[m_sel]) + 1;
                    m_k    = 1;
                    m_st   = 1;
                end
                1: if (m_k == m_len) begin
                    if (!m_wr) m_rdata = m_addr[15:0] ^ 16'h5A3C;
                    m_t  = 1;
                    m_st = 2;
                end else m_k++;
                default: if (m_t == m_tlen) m_st = 0; else m_t++;
            endcase
        end
    end

    // Compare outputs a quarter period after every edge.
    always @(posedge clk) begin
        #(QTR);
        if (rst_n) begin
            automatic bit         act  = (m_st == 1) && enable;
            automatic logic [1:0] ecs  = 2'b11;
            automatic logic       ewe  = !(act && m_wr && (m_k > m_wen + 1));
            automatic logic       eoe  = !(act && !m_wr && (m_k > m_oen));
            automatic logic [1:0] eln  = {!(act && m_be[1]), !(act && m_be[0])};
            automatic logic       edn  = (m_st == 2) && (m_t == 1);
            if (act) ecs[m_sel] = 1'b0;
            check("R8 chip select", 32'(mem_cs_n), 32'(ecs));
            check("R2 write enable", 32'(mem_we_n), 32'(ewe));
            check("R3 read enable", 32'(mem_oe_n), 32'(eoe));
            check("R7 lane strobes", 32'(mem_lane_n), 32'(eln));
            check("R5 data drive", 32'(mem_dq_oe), 32'(!ewe));
            if (!ewe) check("R5 write data", 32'(mem_dq_out), 32'(m_wdata));
            check("R6 R10 ready", 32'(req_ready), 32'((m_st == 0) && enable));
            check("R4 done pulse", 32'(rsp_done), 32'(edn));
            if (edn && !m_wr) check("R4 read data", 32'(rsp_rdata), 32'(m_rdata));
            if (!mem_cs_n[1]) cs1_run++;
            else if (cs1_run != 0) begin cs1_last = cs1_run; cs1_run = 0; end
        end
    end

    task automatic issue(input bit sel, input bit wr, input logic [1:0] be,
                         input logic [22:0] a, input logic [15:0] d);
        @(negedge clk);
        req_sel = sel; req_write = wr; req_be = be; req_addr = a; req_wdata = d;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        b_wen[0] = 4'd0; b_oen[0] = 4'd0; b_rd[0] = 5'd0; b_wr[0] = 5'd0; b_trn[0] = 4'd0;
        b_wen[1] = 4'd3; b_oen[1] = 4'd2; b_rd[1] = 5'd5; b_wr[1] = 5'd4; b_trn[1] = 4'd2;
        repeat (3) @(negedge clk);
        // R1: quiet pins during reset
        check("R1 reset cs", 32'(mem_cs_n), 32'h3);
        check("R1 reset strobes", 32'({mem_oe_n, mem_we_n, mem_lane_n}), 32'hF);
        check("R1 reset bus", 32'({mem_dq_oe, rsp_done}), 32'h0);
        rst_n = 1'b1;
        // R9: held request ignored while disabled
        @(negedge clk);
        enable = 1'b0;
        req_sel = 1'b0; req_write = 1'b0; req_be = 2'b11; req_addr = 23'h1234; req_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R9 disabled cs", 32'(mem_cs_n), 32'h3);
            check("R9 disabled ready", 32'(req_ready), 32'h0);
        end
        enable = 1'b1;
        req_valid = 1'b0;
        // Chip 0 at zero codes
        issue(1'b0, 1'b0, 2'b11, 23'h00ABC, 16'h0);
        issue(1'b0, 1'b1, 2'b01, 23'h00010, 16'hBEEF);
        issue(1'b0, 1'b1, 2'b10, 23'h00011, 16'h1357);
        issue(1'b0, 1'b0, 2'b00, 23'h7F0F0, 16'h0);
        // Chip 1 at mid codes, back to back
        issue(1'b1, 1'b0, 2'b10, 23'h12345, 16'h0);
        issue(1'b1, 1'b1, 2'b11, 23'h22222, 16'hA5A5);
        issue(1'b0, 1'b0, 2'b01, 23'h00F00, 16'h0);
        wait_idle();
        // Chip 1 at saturated top codes
        b_wen[1] = 4'd15; b_oen[1] = 4'd15; b_rd[1] = 5'd31; b_wr[1] = 5'd31; b_trn[1] = 4'd15;
        issue(1'b1, 1'b0, 2'b11, 23'h6ABCD, 16'h0);
        wait_idle();
        check("R4 top read length", 32'(cs1_last), 32'd32);
        issue(1'b1, 1'b1, 2'b11, 23'h01234, 16'h7E81);
        issue(1'b0, 1'b1, 2'b11, 23'h00002, 16'h4242);
        wait_idle();
        check("R5 top write length", 32'(cs1_last), 32'd33);
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule